// File: doc/BRIEF.md
# Delayed Request Discard Timer

This block watches one delayed nonposted request on a bridge whose secondary bus runs in conventional PCI mode. Timing begins only when the completion has returned from the upstream link and can be handed back. At that point a countdown of either 1024 or 32768 secondary clocks starts. A matching retry from the originating master before the count runs out delivers the completion and stops the timer. If the count runs out first, the block pulses a flush strobe so that the held completion is discarded, and it sets a sticky discard status bit.

Escalation is gated by control bits. The status bit asks for a sync flood only when the discard escalation enable is set and the global error-SERR disable is clear. With the same enable set, it also drives the fatal interrupt and the nonfatal interrupt, each through its own enable. Software clears the status bit by writing a one. Buffer storage and bus protocol handling belong to other blocks.

Top module: `drq_discard_timer`

## Requirements
- R1: After reset, flushPulse, deliverPulse, statusOut, syncFloodReq, fatalIrq and nonFatalIrq are all low.
- R2: With longSel low when respReady is sampled, flushPulse is high for exactly one cycle, starting 1024 clock cycles after the edge that sampled respReady, provided no retry is sampled in that window.
- R3: With longSel high when respReady is sampled, the flush happens 32768 cycles after that edge.
- R4: A retryHit sampled while the timer runs produces a one-cycle deliverPulse on the next cycle and returns the timer to idle, with no flush and no change to statusOut.
- R5: A retryHit sampled on the same edge as the expiry wins: deliverPulse is raised and flushPulse is not.
- R6: statusOut goes high in the same cycle as flushPulse and stays high until statusClear is sampled high; when a clear and an expiry are sampled on the same edge, statusOut remains set.
- R7: syncFloodReq equals statusOut AND syncFloodEn AND NOT serrDisable.
- R8: fatalIrq equals statusOut AND syncFloodEn AND fatalEn, and nonFatalIrq equals statusOut AND syncFloodEn AND nonFatalEn.
- R9: respReady while the timer runs does not restart the count, and retryHit while the timer is idle produces no deliverPulse.
- R10: The timeout length is captured when respReady is sampled; a later change of longSel does not alter the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Secondary bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| respReady | input | 1 | Completion is back and ready to return; starts the timer |
| retryHit | input | 1 | The originating master has retried the matching request |
| longSel | input | 1 | Timeout length select: 0 gives 1024 cycles, 1 gives 32768 cycles |
| statusClear | input | 1 | Write-one-to-clear strobe for the discard status bit |
| syncFloodEn | input | 1 | Enables escalation of the discard status |
| serrDisable | input | 1 | Global error-SERR disable; blocks the sync-flood request |
| fatalEn | input | 1 | Routes the discard status to the fatal interrupt |
| nonFatalEn | input | 1 | Routes the discard status to the nonfatal interrupt |
| flushPulse | output | 1 | One-cycle strobe: discard the held completion |
| deliverPulse | output | 1 | One-cycle strobe: hand the completion to the retrying master |
| statusOut | output | 1 | Sticky discard timer status |
| syncFloodReq | output | 1 | Sync-flood request |
| fatalIrq | output | 1 | Fatal interrupt request |
| nonFatalIrq | output | 1 | Nonfatal interrupt request |

## Verification
The bench times the flush to the exact cycle for both timeout lengths. A timer that is off by one cycle, or that starts on the wrong edge, puts the flush on a different cycle and so fails. It also places a retry on the expiry edge and on the edge just after it. A design that let the timeout win would flush and set status where a delivery was due, and one that still took late retries would deliver twice. It also re-asserts respReady partway through a count and flips longSel after the start, which catches a timer that restarts or reads the select live. A clear sampled together with an expiry catches a design that lets the clear win, and a sweep of all sixteen enable combinations catches any misgated escalation output.

// File: rtl/drq_dt_pkg.sv
package drq_dt_pkg;
  // control-to-datapath strobes, all single-cycle
  typedef struct packed {
    logic start;    // completion ready, load the timer
    logic expire;   // timeout reached without a retry
    logic deliver;  // retry matched while waiting
  } dtStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } dtState_t;
endpackage

// File: rtl/drq_dt_ctrl.sv
module drq_dt_ctrl
  import drq_dt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      respReady,
  input  logic      retryHit,
  input  logic      atLimit,
  output dtStrobe_t strobe,
  output logic      busy
);
  dtState_t state, stateNext;

  always_comb begin
    strobe         = '0;
    stateNext      = state;
    strobe.start   = (state == ST_IDLE) && respReady;
    strobe.deliver = (state == ST_WAIT) && retryHit;
    // a retry on the final cycle takes precedence over the timeout
    strobe.expire  = (state == ST_WAIT) && atLimit && !retryHit;
    if (strobe.start) stateNext = ST_WAIT;
    else if (strobe.deliver || strobe.expire) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == ST_WAIT);
endmodule

// File: rtl/drq_dt_dpath.sv
module drq_dt_dpath
  import drq_dt_pkg::*;
#(
  parameter int SHORT_CYCLES = 1024,
  parameter int LONG_CYCLES  = 32768
) (
  input  logic      clk,
  input  logic      rstN,
  input  dtStrobe_t strobe,
  input  logic      busy,
  input  logic      longSel,
  input  logic      statusClear,
  input  logic      syncFloodEn,
  input  logic      serrDisable,
  input  logic      fatalEn,
  input  logic      nonFatalEn,
  output logic      atLimit,
  output logic      flushPulse,
  output logic      deliverPulse,
  output logic      statusOut,
  output logic      syncFloodReq,
  output logic      fatalIrq,
  output logic      nonFatalIrq
);
  localparam int MAX_CYCLES = (LONG_CYCLES > SHORT_CYCLES) ? LONG_CYCLES : SHORT_CYCLES;
  localparam int CNT_W      = $clog2(MAX_CYCLES);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYCLES - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYCLES - 1);

  logic [CNT_W-1:0] elapsed;
  logic             lenLong;   // length select captured at start

  always_ff @(posedge clk) begin
    if (!rstN) begin
      elapsed <= '0;
      lenLong <= 1'b0;
    end else if (strobe.start) begin
      elapsed <= '0;
      lenLong <= longSel;
    end else if (busy) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  assign atLimit = (elapsed == (lenLong ? LONG_LAST : SHORT_LAST));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flushPulse   <= 1'b0;
      deliverPulse <= 1'b0;
      statusOut    <= 1'b0;
    end else begin
      flushPulse   <= strobe.expire;
      deliverPulse <= strobe.deliver;
      // setting on expiry outranks a simultaneous software clear
      if (strobe.expire)    statusOut <= 1'b1;
      else if (statusClear) statusOut <= 1'b0;
    end
  end

  logic escalate;
  assign escalate     = statusOut && syncFloodEn;
  assign syncFloodReq = escalate && !serrDisable;
  assign fatalIrq     = escalate && fatalEn;
  assign nonFatalIrq  = escalate && nonFatalEn;
endmodule

// File: rtl/drq_discard_timer.sv
module drq_discard_timer
  import drq_dt_pkg::*;
#(
  parameter int SHORT_CYCLES = 1024,
  parameter int LONG_CYCLES  = 32768
) (
  input  logic clk,
  input  logic rstN,
  input  logic respReady,
  input  logic retryHit,
  input  logic longSel,
  input  logic statusClear,
  input  logic syncFloodEn,
  input  logic serrDisable,
  input  logic fatalEn,
  input  logic nonFatalEn,
  output logic flushPulse,
  output logic deliverPulse,
  output logic statusOut,
  output logic syncFloodReq,
  output logic fatalIrq,
  output logic nonFatalIrq
);
  dtStrobe_t strobe;
  logic      busy;
  logic      atLimit;

  drq_dt_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .respReady (respReady),
    .retryHit  (retryHit),
    .atLimit   (atLimit),
    .strobe    (strobe),
    .busy      (busy)
  );

  drq_dt_dpath #(
    .SHORT_CYCLES (SHORT_CYCLES),
    .LONG_CYCLES  (LONG_CYCLES)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .busy         (busy),
    .longSel      (longSel),
    .statusClear  (statusClear),
    .syncFloodEn  (syncFloodEn),
    .serrDisable  (serrDisable),
    .fatalEn      (fatalEn),
    .nonFatalEn   (nonFatalEn),
    .atLimit      (atLimit),
    .flushPulse   (flushPulse),
    .deliverPulse (deliverPulse),
    .statusOut    (statusOut),
    .syncFloodReq (syncFloodReq),
    .fatalIrq     (fatalIrq),
    .nonFatalIrq  (nonFatalIrq)
  );
endmodule

// File: rtl/drq_discard_timer_chk.sv
module drq_discard_timer_chk (
  input logic clk,
  input logic rstN,
  input logic statusClear,
  input logic syncFloodEn,
  input logic serrDisable,
  input logic fatalEn,
  input logic nonFatalEn,
  input logic flushPulse,
  input logic deliverPulse,
  input logic statusOut,
  input logic syncFloodReq,
  input logic fatalIrq,
  input logic nonFatalIrq
);
  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    flushPulse |=> !flushPulse); // R2
  AST_DELIVER_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    deliverPulse |=> !deliverPulse); // R4
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    !(flushPulse && deliverPulse)); // R5
  AST_FLUSH_SETS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    flushPulse |-> statusOut); // R6
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut && !statusClear) |=> statusOut); // R6
  AST_STATUS_RISE_ON_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut) |-> flushPulse); // R6
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    statusClear |=> (!statusOut || flushPulse)); // R6
  AST_FLOOD_GATE: assert property (@(posedge clk) disable iff (!rstN)
    syncFloodReq |-> (statusOut && syncFloodEn && !serrDisable)); // R7
  AST_FATAL_GATE: assert property (@(posedge clk) disable iff (!rstN)
    fatalIrq |-> (statusOut && syncFloodEn && fatalEn)); // R8
  AST_NONFATAL_GATE: assert property (@(posedge clk) disable iff (!rstN)
    nonFatalIrq |-> (statusOut && syncFloodEn && nonFatalEn)); // R8
endmodule

bind drq_discard_timer drq_discard_timer_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .statusClear  (statusClear),
  .syncFloodEn  (syncFloodEn),
  .serrDisable  (serrDisable),
  .fatalEn      (fatalEn),
  .nonFatalEn   (nonFatalEn),
  .flushPulse   (flushPulse),
  .deliverPulse (deliverPulse),
  .statusOut    (statusOut),
  .syncFloodReq (syncFloodReq),
  .fatalIrq     (fatalIrq),
  .nonFatalIrq  (nonFatalIrq)
);

// File: tb/drq_discard_timer_tb.sv
`timescale 1ns/1ps
module drq_discard_timer_tb;
  localparam int SHORT_N = 1024;
  localparam int LONG_N  = 32768;
  localparam int EV_FLUSH   = 1;
  localparam int EV_DELIVER = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic respReady = 1'b0, retryHit = 1'b0, longSel = 1'b0, statusClear = 1'b0;
  logic syncFloodEn = 1'b0, serrDisable = 1'b0, fatalEn = 1'b0, nonFatalEn = 1'b0;
  logic flushPulse, deliverPulse, statusOut, syncFloodReq, fatalIrq, nonFatalIrq;

  always #10 clk = ~clk;  // 50 MHz

  drq_discard_timer u_dut (
    .clk(clk), .rstN(rstN), .respReady(respReady), .retryHit(retryHit),
    .longSel(longSel), .statusClear(statusClear), .syncFloodEn(syncFloodEn),
    .serrDisable(serrDisable), .fatalEn(fatalEn), .nonFatalEn(nonFatalEn),
    .flushPulse(flushPulse), .deliverPulse(deliverPulse), .statusOut(statusOut),
    .syncFloodReq(syncFloodReq), .fatalIrq(fatalIrq), .nonFatalIrq(nonFatalIrq)
  );

  typedef struct {
    int     kind;
    longint when;
    string  tag;
  } evItem_t;

  evItem_t expQ[$];
  int      checks = 0;
  int      errors = 0;
  longint  cyc = 0;
  bit      finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expectEv(int kind, longint when, string tag);
    evItem_t it;
    it.kind = kind; it.when = when; it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: every strobe seen must match the head of the queue
  always @(negedge clk) begin
    if (rstN && (flushPulse || deliverPulse)) begin
      if (expQ.size() == 0) begin
        check("R9 unexpected strobe", {flushPulse, deliverPulse}, 0);
      end else begin
        evItem_t it;
        it = expQ.pop_front();
        check({it.tag, " kind"}, flushPulse ? EV_FLUSH : EV_DELIVER, it.kind);
        check({it.tag, " cycle"}, cyc, it.when);
      end
    end
  end

  task automatic waitUntil(longint t);
    while (cyc < t) @(negedge clk);
  endtask

  // drive respReady for one cycle; returns the cycle index of the drive
  task automatic startReq(output longint c);
    @(negedge clk);
    c = cyc;
    respReady = 1'b1;
    @(negedge clk);
    respReady = 1'b0;
  endtask

  task automatic pulseRetry();
    retryHit = 1'b1;
    @(negedge clk);
    retryHit = 1'b0;
  endtask

  task automatic pulseClear();
    statusClear = 1'b1;
    @(negedge clk);
    statusClear = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    longint c;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 outputs after reset",
          {flushPulse, deliverPulse, statusOut, syncFloodReq, fatalIrq, nonFatalIrq}, 0);

    // R2 short timeout
    longSel = 1'b0;
    startReq(c);
    expectEv(EV_FLUSH, c + 1 + SHORT_N, "R2 short flush");
    waitUntil(c + 1 + SHORT_N);
    check("R6 status set at flush", statusOut, 1);
    @(negedge clk);
    check("R2 flush one cycle", flushPulse, 0);
    check("R6 status holds", statusOut, 1);

    // R7 R8 escalation sweep
    for (int m = 0; m < 16; m++) begin
      {syncFloodEn, serrDisable, fatalEn, nonFatalEn} = m[3:0];
      #1;
      check("R7 sync flood gate", syncFloodReq, m[3] && !m[2]);
      check("R8 fatal/nonfatal gate", {fatalIrq, nonFatalIrq}, {m[3] && m[1], m[3] && m[0]});
      @(negedge clk);
    end
    syncFloodEn = 1'b1; fatalEn = 1'b1; nonFatalEn = 1'b1; serrDisable = 1'b0;

    // R6 clear
    pulseClear();
    check("R6 clear status", statusOut, 0);
    check("R7 R8 drop with status", {syncFloodReq, fatalIrq, nonFatalIrq}, 0);

    // R4 retry mid-count
    startReq(c);
    waitUntil(c + 200);
    expectEv(EV_DELIVER, cyc + 1, "R4 mid retry");
    pulseRetry();
    waitUntil(c + SHORT_N + 20);
    check("R4 status unchanged", statusOut, 0);

    // R5 retry on expiry edge
    startReq(c);
    waitUntil(c + SHORT_N);
    expectEv(EV_DELIVER, c + 1 + SHORT_N, "R5 retry wins");
    pulseRetry();
    waitUntil(c + SHORT_N + 20);
    check("R5 no status", statusOut, 0);

    // R9 late retry ignored, R6 clear loses to expiry
    startReq(c);
    expectEv(EV_FLUSH, c + 1 + SHORT_N, "R9 late retry flush");
    waitUntil(c + SHORT_N);
    statusClear = 1'b1;
    @(negedge clk);
    statusClear = 1'b0;
    check("R6 set beats clear", statusOut, 1);
    pulseRetry();
    repeat (10) @(negedge clk);
    check("R9 queue drained after late retry", expQ.size(), 0);
    pulseClear();
    check("R6 clear again", statusOut, 0);

    // R9 respReady while running does not restart
    startReq(c);
    expectEv(EV_FLUSH, c + 1 + SHORT_N, "R9 no restart");
    waitUntil(c + 500);
    respReady = 1'b1;
    @(negedge clk);
    respReady = 1'b0;
    waitUntil(c + SHORT_N + 20);
    pulseClear();

    // R9 retry while idle
    pulseRetry();
    repeat (5) @(negedge clk);
    check("R9 idle retry no deliver", expQ.size(), 0);

    // R3 long timeout, R10 select captured at start
    longSel = 1'b1;
    startReq(c);
    longSel = 1'b0;
    expectEv(EV_FLUSH, c + 1 + LONG_N, "R3 R10 long flush");
    waitUntil(c + 1 + SHORT_N + 5);
    check("R10 no short expiry", statusOut, 0);
    waitUntil(c + LONG_N + 20);
    check("R3 status after long", statusOut, 1);
    check("R7 flood raised", syncFloodReq, 1);

    check("R2 all expected strobes seen", expQ.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule